// File: doc/BRIEF.md
# Byte FIFO with Memory Drain and Pointer Reset

This block is a byte-wide FIFO that sits between a SCSI data path and a memory bus master. It has two control bits. The drain bit (flush) empties the FIFO to memory as a series of write requests. The reset bit (clear) throws away the queued bytes. The producer writes bytes with `push_en`. A consumer can take them one at a time with `pop_en`. The last byte taken stays visible on `pop_data`.

A flush starts from an address loaded into the next-address register. Each byte goes out as one request on a request/acknowledge port, and the address rises by one after every acknowledged beat. The flush bit is sticky. It stays set after the FIFO is empty and the done flag is raised, until software writes it back to zero. The clear bit drops by itself once the pointers are zero.

A small controller has four states:
- **IDLE** waits for a control bit.
  - IDLE→CLEAR when the clear bit is set. This has priority.
  - IDLE→DONE when the flush bit is set and the FIFO is empty or the direction input is low.
  - IDLE→DRAIN when the flush bit is set, the FIFO holds data and the direction input is high.
- **CLEAR** zeroes the pointers for one cycle, then goes CLEAR→IDLE.
- **DRAIN** holds a request.
  - DRAIN→CLEAR on a clear.
  - DRAIN→DONE when the last byte is acknowledged.
  - DRAIN→IDLE if software drops the flush bit.
- **DONE** reports completion.
  - DONE→CLEAR on a clear.
  - DONE→IDLE when the flush bit is written to zero.

Top module: `drain_fifo`

## Requirements
- R1: After reset the block reports empty=1, full=0, count=0, no memory request, flush and clear bits 0, done 0, and `pop_data` 0.
- R2: A push is stored only when the FIFO is not full. A pop gives the oldest byte on `pop_data` one cycle after the pop cycle. A push into a full FIFO is ignored.
- R3: `st_count` equals the number of bytes held (0 to DEPTH). `st_empty` is set exactly when the count is 0. `st_full` is set exactly when the count is DEPTH.
- R4: With the direction input high, a flush sends every held byte in FIFO order as write requests. The first address is the loaded next-address value. The address rises by one, modulo 2^AW, after each acknowledged beat. Address and data stay stable while a request waits for acknowledge.
- R5: During a flush the count, empty and full outputs stay correct. The count drops by one per acknowledged beat.
- R6: When a flush has emptied the FIFO, `flush_done` is set. The flush bit stays set until software writes it to 0, and `flush_done` then returns to 0.
- R7: A flush started on an empty FIFO sets `flush_done` within two cycles and issues no memory request.
- R8: A flush started with the direction input low issues no memory request. It sets `flush_done` and leaves the FIFO contents unchanged.
- R9: Writing the clear bit (control bit 1) sets the count to 0 and drops the queued bytes. The clear bit reads 1 and then returns to 0 by itself within two cycles. `pop_data` is not changed.
- R10: When clear and flush (control bit 0) are written together, the clear is done first. No memory request is issued, and the flush then completes as on an empty FIFO.
- R11: While the flush bit is set, pushes and pops at the FIFO ports are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_en | input | 1 | Push one byte from the SCSI side |
| push_data | input | DW | Byte to push |
| pop_en | input | 1 | Pop one byte |
| pop_data | output | DW | Last popped byte |
| ctl_we | input | 1 | Write the control bits |
| ctl_wdata | input | 2 | Bit 0 flush, bit 1 clear |
| to_mem | input | 1 | Transfer direction, 1 = toward memory |
| addr_we | input | 1 | Load the next-address register (ignored while draining) |
| addr_wdata | input | AW | Next-address value |
| mreq | output | 1 | Memory write request |
| maddr | output | AW | Request address |
| mdata | output | DW | Request data |
| mack | input | 1 | Memory acknowledge, beat completes on mreq and mack |
| st_empty | output | 1 | FIFO empty |
| st_full | output | 1 | FIFO full |
| st_count | output | $clog2(DEPTH)+1 | Bytes held |
| flush_bit | output | 1 | Flush control bit |
| clear_bit | output | 1 | Clear control bit |
| flush_done | output | 1 | Flush completed |

## Verification
The bench builds the block with DEPTH 16, DW 8 and AW 8. With that depth, the FIFO fills to full in a few pushes, so the full-push case is quick to reach. With 8-bit addresses, a drain started at 0xFA crosses the 0xFF to 0x00 wrap partway through the burst. The memory model varies its acknowledge delay from beat to beat, which keeps requests waiting across several cycles. Pushes and pops issued during that wait test the blocking rule.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } dstate_t;
endpackage

// File: rtl/dfifo_store.sv
module dfifo_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [DW-1:0]            wr_data,
    input  logic                     rd_en,
    input  logic                     drain_en,
    input  logic                     zap,
    output logic [DW-1:0]            head,
    output logic [DW-1:0]            out_q,
    output logic [$clog2(DEPTH):0]   cnt,
    output logic                     empty,
    output logic                     full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic          do_wr;
    logic          do_rd;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign head  = mem[rptr];
    assign do_wr = wr_en && !full && !zap;
    assign do_rd = (rd_en || drain_en) && !empty && !zap;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else if (zap) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_wr) wptr <= bump(wptr);
            if (do_rd) rptr <= bump(rptr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (zap) begin
            cnt <= '0;
        end else if (do_wr && !do_rd) begin
            cnt <= cnt + 1'b1;
        end else if (!do_wr && do_rd) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (rd_en && do_rd) begin
            out_q <= mem[rptr];
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R3
    AST_ZAP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        zap |=> (cnt == '0)); // R9
    AST_ZAP_KEEPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        zap |=> $stable(out_q)); // R9
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !drain_en && !zap) |=> (cnt == $past(cnt))); // R2
endmodule

// File: rtl/dfifo_addr.sv
module dfifo_addr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/dfifo_fsm.sv
module dfifo_fsm
    import dfifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [1:0] ctl_wdata,
    input  logic       to_mem,
    input  logic       fifo_empty,
    input  logic       fifo_last,
    input  logic       mack,
    output dstate_t    state,
    output logic       flush_q,
    output logic       clear_q,
    output logic       zap,
    output logic       mreq,
    output logic       drain_pop,
    output logic       done
);
    dstate_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (clear_q) begin
                    nxt = ST_CLEAR;
                end else if (flush_q) begin
                    nxt = (fifo_empty || !to_mem) ? ST_DONE : ST_DRAIN;
                end
            end
            ST_CLEAR: nxt = ST_IDLE;
            ST_DRAIN: begin
                if (clear_q) begin
                    nxt = ST_CLEAR;
                end else if (mack && fifo_last) begin
                    nxt = ST_DONE;
                end else if (!flush_q) begin
                    nxt = ST_IDLE;
                end
            end
            ST_DONE: begin
                if (clear_q) begin
                    nxt = ST_CLEAR;
                end else if (!flush_q) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        zap       = 1'b0;
        mreq      = 1'b0;
        drain_pop = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_CLEAR: zap = 1'b1;
            ST_DRAIN: begin
                mreq      = 1'b1;
                drain_pop = mack;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flush_q <= 1'b0;
            clear_q <= 1'b0;
        end else if (ctl_we) begin
            flush_q <= ctl_wdata[0];
            clear_q <= ctl_wdata[1];
        end else if (state == ST_CLEAR) begin
            clear_q <= 1'b0;
        end
    end

    AST_FLUSH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_q && !ctl_we) |=> flush_q); // R6
    AST_CLEAR_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR && !ctl_we) |=> !clear_q); // R9
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && clear_q) |=> (state == ST_CLEAR)); // R10
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mreq, zap, done})); // R6
endmodule

// File: rtl/drain_fifo.sv
module drain_fifo
    import dfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int AW    = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push_en,
    input  logic [DW-1:0]          push_data,
    input  logic                   pop_en,
    output logic [DW-1:0]          pop_data,
    input  logic                   ctl_we,
    input  logic [1:0]             ctl_wdata,
    input  logic                   to_mem,
    input  logic                   addr_we,
    input  logic [AW-1:0]          addr_wdata,
    output logic                   mreq,
    output logic [AW-1:0]          maddr,
    output logic [DW-1:0]          mdata,
    input  logic                   mack,
    output logic                   st_empty,
    output logic                   st_full,
    output logic [$clog2(DEPTH):0] st_count,
    output logic                   flush_bit,
    output logic                   clear_bit,
    output logic                   flush_done
);
    localparam int CW = $clog2(DEPTH) + 1;

    dstate_t state;
    logic    zap;
    logic    drain_pop;
    logic    fifo_last;
    logic    wr_gate;
    logic    rd_gate;
    logic    addr_load;

    assign fifo_last = (st_count == CW'(1));
    assign wr_gate   = push_en && !flush_bit;
    assign rd_gate   = pop_en && !flush_bit;
    assign addr_load = addr_we && (state != ST_DRAIN);

    dfifo_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .to_mem     (to_mem),
        .fifo_empty (st_empty),
        .fifo_last  (fifo_last),
        .mack       (mack),
        .state      (state),
        .flush_q    (flush_bit),
        .clear_q    (clear_bit),
        .zap        (zap),
        .mreq       (mreq),
        .drain_pop  (drain_pop),
        .done       (flush_done)
    );

    dfifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_gate),
        .wr_data  (push_data),
        .rd_en    (rd_gate),
        .drain_en (drain_pop),
        .zap      (zap),
        .head     (mdata),
        .out_q    (pop_data),
        .cnt      (st_count),
        .empty    (st_empty),
        .full     (st_full)
    );

    dfifo_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load),
        .load_val (addr_wdata),
        .step     (drain_pop),
        .addr     (maddr)
    );

    AST_REQ_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        mreq |-> !st_empty); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq && mack) |=> (maddr == $past(maddr) + 1'b1)); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq && !mack && flush_bit && !clear_bit)
            |=> (mreq && $stable(maddr) && $stable(mdata))); // R4
    AST_PUSH_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_bit && push_en && !zap) |=> (st_count <= $past(st_count))); // R11
endmodule

// File: tb/drain_fifo_tb_top.sv
module drain_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int AW    = 8;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_en = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic          pop_en = 1'b0;
    logic [DW-1:0] pop_data;
    logic          ctl_we = 1'b0;
    logic [1:0]    ctl_wdata = '0;
    logic          to_mem = 1'b1;
    logic          addr_we = 1'b0;
    logic [AW-1:0] addr_wdata = '0;
    logic          mreq;
    logic [AW-1:0] maddr;
    logic [DW-1:0] mdata;
    logic          mack = 1'b0;
    logic          st_empty;
    logic          st_full;
    logic [CW-1:0] st_count;
    logic          flush_bit;
    logic          clear_bit;
    logic          flush_done;

    int n_cmp = 0;
    int n_bad = 0;
    int beats = 0;
    int lat_cnt = 0;
    int lat_pick = 0;
    bit finished = 0;

    logic [DW-1:0]      model_q[$];
    logic [AW+DW-1:0]   exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    drain_fifo #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_data(push_data),
        .pop_en(pop_en), .pop_data(pop_data), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .to_mem(to_mem), .addr_we(addr_we), .addr_wdata(addr_wdata),
        .mreq(mreq), .maddr(maddr), .mdata(mdata), .mack(mack),
        .st_empty(st_empty), .st_full(st_full), .st_count(st_count),
        .flush_bit(flush_bit), .clear_bit(clear_bit), .flush_done(flush_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            mack = 1'b0;
        end else if (mack) begin
            mack = 1'b0;
        end else if (mreq) begin
            if (lat_cnt < lat_pick) begin
                lat_cnt++;
            end else begin
                lat_cnt = 0;
                lat_pick = (lat_pick + 1) % 3;
                beats++;
                if (exp_q.size() == 0) begin
                    chk("R10 unexpected request", 32'(maddr), 32'hFFFF_FFFF);
                end else begin
                    chk("R5 count during drain", 32'(st_count), 32'(exp_q.size()));
                    begin
                        logic [AW+DW-1:0] e;
                        e = exp_q.pop_front();
                        chk("R4 address", 32'(maddr), 32'(e[AW+DW-1:DW]));
                        chk("R4 data", 32'(mdata), 32'(e[DW-1:0]));
                    end
                end
                mack = 1'b1;
            end
        end
    end

    task automatic push_b(input logic [DW-1:0] d);
        @(negedge clk);
        push_en = 1'b1;
        push_data = d;
        @(negedge clk);
        push_en = 1'b0;
        if (!flush_bit && model_q.size() < DEPTH) model_q.push_back(d);
    endtask

    task automatic pop_chk();
        logic [DW-1:0] e;
        @(negedge clk);
        pop_en = 1'b1;
        @(negedge clk);
        pop_en = 1'b0;
        e = model_q.pop_front();
        chk("R2 pop order", 32'(pop_data), 32'(e));
    endtask

    task automatic ctl_write(input logic [1:0] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic load_addr(input logic [AW-1:0] a);
        @(negedge clk);
        addr_we = 1'b1;
        addr_wdata = a;
        @(negedge clk);
        addr_we = 1'b0;
    endtask

    // driver: queue expected beats, then start the drain
    task automatic start_flush(input logic [AW-1:0] base);
        int i = 0;
        load_addr(base);
        while (model_q.size() > 0) begin
            logic [DW-1:0] b;
            logic [AW-1:0] a;
            b = model_q.pop_front();
            a = base + AW'(i);
            exp_q.push_back({a, b});
            i++;
        end
        ctl_write(2'b01);
    endtask

    task automatic wait_done();
        for (int k = 0; k < 200 && !flush_done; k++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [DW-1:0] held;
        int b0;
        #(CLK_PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 empty", 32'(st_empty), 1);
        chk("R1 full", 32'(st_full), 0);
        chk("R1 count", 32'(st_count), 0);
        chk("R1 mreq", 32'(mreq), 0);
        chk("R1 bits", 32'({flush_bit, clear_bit, flush_done}), 0);
        chk("R1 pop_data", 32'(pop_data), 0);

        // R2 R3 basic order and counting
        for (int i = 0; i < 5; i++) push_b(DW'(8'h30 + i));
        chk("R3 count 5", 32'(st_count), 5);
        chk("R3 not empty", 32'(st_empty), 0);
        pop_chk();
        pop_chk();
        chk("R3 count 3", 32'(st_count), 3);

        // fill to full and over-push
        for (int i = 0; i < DEPTH - 3; i++) push_b(DW'(8'hA0 + i));
        chk("R3 full flag", 32'(st_full), 1);
        chk("R3 count full", 32'(st_count), DEPTH);
        push_b(8'hEE);
        chk("R2 push when full ignored", 32'(st_count), DEPTH);

        // R4 R5 R6 R11 drain across address wrap with blocked port activity
        held = pop_data;
        start_flush(8'hFA);
        push_b(8'h55);
        @(negedge clk);
        pop_en = 1'b1;
        @(negedge clk);
        pop_en = 1'b0;
        chk("R11 pop ignored", 32'(pop_data), 32'(held));
        wait_done();
        chk("R6 done set", 32'(flush_done), 1);
        chk("R4 all beats sent", 32'(exp_q.size()), 0);
        chk("R11 push ignored count", 32'(st_count), 0);
        chk("R5 empty after drain", 32'(st_empty), 1);
        idle(4);
        chk("R6 flush bit sticky", 32'(flush_bit), 1);
        chk("R6 done held", 32'(flush_done), 1);
        ctl_write(2'b00);
        idle(1);
        chk("R6 done clears", 32'(flush_done), 0);

        // R7 empty flush
        b0 = beats;
        ctl_write(2'b01);
        idle(2);
        chk("R7 done on empty", 32'(flush_done), 1);
        chk("R7 no requests", 32'(beats), 32'(b0));
        ctl_write(2'b00);

        // R8 direction low
        for (int i = 0; i < 3; i++) push_b(DW'(8'h70 + i));
        to_mem = 1'b0;
        b0 = beats;
        ctl_write(2'b01);
        idle(3);
        chk("R8 done", 32'(flush_done), 1);
        chk("R8 no requests", 32'(beats), 32'(b0));
        chk("R8 contents kept", 32'(st_count), 3);
        ctl_write(2'b00);
        to_mem = 1'b1;
        pop_chk();

        // R9 clear
        held = pop_data;
        ctl_write(2'b10);
        chk("R9 clear bit set", 32'(clear_bit), 1);
        idle(2);
        chk("R9 clear self reset", 32'(clear_bit), 0);
        chk("R9 count zero", 32'(st_count), 0);
        chk("R9 empty", 32'(st_empty), 1);
        chk("R9 pop_data kept", 32'(pop_data), 32'(held));
        model_q.delete();
        push_b(8'h9C);
        pop_chk();

        // R10 clear and flush together
        for (int i = 0; i < 4; i++) push_b(DW'(8'hC0 + i));
        model_q.delete();
        b0 = beats;
        ctl_write(2'b11);
        idle(5);
        chk("R10 no requests", 32'(beats), 32'(b0));
        chk("R10 count zero", 32'(st_count), 0);
        chk("R10 done", 32'(flush_done), 1);
        chk("R10 clear bit dropped", 32'(clear_bit), 0);
        ctl_write(2'b00);

        // second drain, different base
        for (int i = 0; i < 6; i++) push_b(DW'(8'h11 * (i + 1)));
        start_flush(8'h10);
        wait_done();
        chk("R4 second drain done", 32'(exp_q.size()), 0);
        chk("R6 second done", 32'(flush_done), 1);
        ctl_write(2'b00);
        idle(2);
        finish_run();
    end
endmodule